// File: doc/BRIEF.md
# Event Timer Main Counter

This block is the time base and global control of a multi-channel event timer. It holds a 64-bit up-counter that advances once per clock while a run bit in the global configuration word is set, and freezes when that bit is cleared. Software reaches the block over a simple 32-bit register bus with single-cycle write and read strobes. Read data is registered and appears one cycle after the read strobe. The counter is visible as a low and a high word, and the high word sits four bytes above the low word. Both words can be loaded, but only while the counter is halted.

Read-only words report two things. One is the number of comparator channels minus one, together with a flag that says whether legacy interrupt routing is available. The other is the length of one count tick in femtoseconds. A sticky status word holds one interrupt flag per comparator channel. A channel's hit pulse sets its flag, and writing a one to the flag clears it. The block drives the live count, the run state and the legacy-routing enable out to the comparator channels. Those channels lie outside this block.

Register offsets (byte addresses): identity 0x00, period 0x04, config 0x10, status 0x20, count low 0x30, count high 0x34. Any other offset, including unaligned ones, is unmapped.

Top module: `evt_main_counter`

## Requirements
- R1: After reset the count is 0, the config word is 0, every status flag is 0, and counterRun and legacyRouteEn are low.
- R2: While config bit 0 (run) is 1, the count rises by exactly one on every clock, with carry from the low word into the high word. While run is 0 the count holds its value.
- R3: Writing offset 0x30 replaces count bits [31:0], and writing offset 0x34 replaces bits [63:32], but only while run is 0. While run is 1, such writes leave the count unchanged.
- R4: Reading 0x30 returns count bits [31:0] and captures count bits [63:32] in the same cycle. A later read of 0x34 returns the captured value, not the live high word.
- R5: Reading 0x00 returns NUM_CHAN-1 in bits [4:0] and the legacy-routing capability in bit 8. All other bits read 0.
- R6: Reading 0x04 returns the PERIOD_FS parameter, which is non-zero and within the range checked at elaboration.
- R7: Config bit 1 (legacy routing) can be written only when LEGACY_CAP is 1, and it drives legacyRouteEn. A config read returns bits [1:0] with bits [31:2] at 0, so the word never reads all ones.
- R8: A chanHit[i] pulse sets status bit i, and the bit stays set. Writing 0x20 clears every bit written as one and leaves bits written as zero untouched. If a hit and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: Read data is valid the cycle after busRdEn and is 0 in any cycle without a read. Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| chanHit | input | NUM_CHAN | Per-channel interrupt set pulses from the comparators |
| countValue | output | 64 | Live count for the comparators |
| counterRun | output | 1 | Config run bit |
| legacyRouteEn | output | 1 | Config legacy-routing bit |

## Verification
Two functions of this block can land on the same status bit in one cycle: a comparator hit that sets the bit and a software write-one that clears it. The bench drives a status write with the same bit raised on chanHit in that cycle, then reads the status back. The bit must still read as set. Two other collisions get the same treatment. A count-word load is issued while the counter runs, which must leave the count unchanged. A low-word read is placed just as the count carries into the high word, and the follow-up high-word read must match the captured half.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam logic [15:0] OFF_IDENT  = 16'h0000;
  localparam logic [15:0] OFF_PERIOD = 16'h0004;
  localparam logic [15:0] OFF_CFG    = 16'h0010;
  localparam logic [15:0] OFF_STATUS = 16'h0020;
  localparam logic [15:0] OFF_CNT_LO = 16'h0030;
  localparam logic [15:0] OFF_CNT_HI = 16'h0034;

  localparam int CFG_RUN_BIT    = 0;
  localparam int CFG_LEGACY_BIT = 1;
  localparam int LEGACY_CAP_BIT = 8;

  localparam logic [31:0] PERIOD_MIN_FS = 32'd100_000;
  localparam logic [31:0] PERIOD_MAX_FS = 32'd100_000_000;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IDENT,
    SEL_PERIOD,
    SEL_CFG,
    SEL_STATUS,
    SEL_CNT_LO,
    SEL_CNT_HI
  } regSel_e;

  typedef struct packed {
    logic    wrCfg;
    logic    wrCntLo;
    logic    wrCntHi;
    logic    wrStatus;
    logic    rdEn;
    regSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/evt_bus_ctrl.sv
module evt_bus_ctrl
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes
);

  regSel_e addrSel;

  always_comb begin
    addrSel = SEL_NONE;
    if      (busAddr == OFF_IDENT[ADDR_W-1:0])  addrSel = SEL_IDENT;
    else if (busAddr == OFF_PERIOD[ADDR_W-1:0]) addrSel = SEL_PERIOD;
    else if (busAddr == OFF_CFG[ADDR_W-1:0])    addrSel = SEL_CFG;
    else if (busAddr == OFF_STATUS[ADDR_W-1:0]) addrSel = SEL_STATUS;
    else if (busAddr == OFF_CNT_LO[ADDR_W-1:0]) addrSel = SEL_CNT_LO;
    else if (busAddr == OFF_CNT_HI[ADDR_W-1:0]) addrSel = SEL_CNT_HI;
  end

  always_comb begin
    strobes.wrCfg    = busWrEn && (addrSel == SEL_CFG);
    strobes.wrCntLo  = busWrEn && (addrSel == SEL_CNT_LO);
    strobes.wrCntHi  = busWrEn && (addrSel == SEL_CNT_HI);
    strobes.wrStatus = busWrEn && (addrSel == SEL_STATUS);
    strobes.rdEn     = busRdEn;
    strobes.rdSel    = busRdEn ? addrSel : SEL_NONE;
  end

endmodule

// File: rtl/evt_counter_dp.sv
module evt_counter_dp
  import evt_timer_pkg::*;
#(
  parameter int          NUM_CHAN   = 3,
  parameter logic [31:0] PERIOD_FS  = 32'd69_841_279,
  parameter bit          LEGACY_CAP = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [31:0]         wrData,
  input  logic [NUM_CHAN-1:0] chanHit,
  output logic [31:0]         rdData,
  output logic [63:0]         countValue,
  output logic                runOut,
  output logic                legacyOut
);

  localparam logic [31:0] IDENT_WORD =
    32'(NUM_CHAN - 1) | (LEGACY_CAP ? (32'h1 << LEGACY_CAP_BIT) : 32'h0);

  logic [63:0]         countReg;
  logic [31:0]         hiLatch;
  logic                runReg;
  logic                legacyReg;
  logic [NUM_CHAN-1:0] statusReg;
  logic [31:0]         rdNext;

  // count: advance while running, loadable halves only while halted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg <= '0;
    end else if (runReg) begin
      countReg <= countReg + 64'd1;
    end else if (strobes.wrCntLo) begin
      countReg[31:0] <= wrData;
    end else if (strobes.wrCntHi) begin
      countReg[63:32] <= wrData;
    end
  end

  // global configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg    <= 1'b0;
      legacyReg <= 1'b0;
    end else if (strobes.wrCfg) begin
      runReg    <= wrData[CFG_RUN_BIT];
      legacyReg <= LEGACY_CAP && wrData[CFG_LEGACY_BIT];
    end
  end

  // sticky per-channel flags; a hit outranks a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0;
    end else begin
      statusReg <= (statusReg & ~(strobes.wrStatus ? wrData[NUM_CHAN-1:0] : '0)) | chanHit;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      SEL_IDENT:  rdNext = IDENT_WORD;
      SEL_PERIOD: rdNext = PERIOD_FS;
      SEL_CFG:    rdNext = {30'd0, legacyReg, runReg};
      SEL_STATUS: rdNext = 32'(statusReg);
      SEL_CNT_LO: rdNext = countReg[31:0];
      SEL_CNT_HI: rdNext = hiLatch;
      default:    rdNext = 32'd0;
    endcase
  end

  // registered read port with the high-half snapshot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      hiLatch <= '0;
    end else begin
      rdData <= rdNext;
      if (strobes.rdSel == SEL_CNT_LO) hiLatch <= countReg[63:32];
    end
  end

  assign countValue = countReg;
  assign runOut     = runReg;
  assign legacyOut  = legacyReg;

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    runReg |=> (countReg == $past(countReg) + 64'd1));

  // R2 R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runReg && !strobes.wrCntLo && !strobes.wrCntHi) |=> $stable(countReg));

  // R8
  hit_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanHit != '0) |=> ((statusReg & $past(chanHit)) == $past(chanHit)));

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrStatus && chanHit == '0) |=>
      ((statusReg & $past(wrData[NUM_CHAN-1:0])) == '0));

  // R7
  cfg_never_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdSel == SEL_CFG) |=> (rdData[31:2] == 30'd0));

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
  import evt_timer_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          NUM_CHAN   = 3,
  parameter logic [31:0] PERIOD_FS  = 32'd69_841_279,
  parameter bit          LEGACY_CAP = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic [NUM_CHAN-1:0] chanHit,
  output logic [63:0]         countValue,
  output logic                counterRun,
  output logic                legacyRouteEn
);

  initial begin
    if (NUM_CHAN < 1 || NUM_CHAN > 32)
      $error("NUM_CHAN must be between 1 and 32");
    if (PERIOD_FS < PERIOD_MIN_FS || PERIOD_FS > PERIOD_MAX_FS)
      $error("PERIOD_FS outside the allowed tick range");
    if (ADDR_W < 6)
      $error("ADDR_W too narrow for the register offsets");
  end

  ctrlStrobes_t strobes;

  evt_bus_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  evt_counter_dp #(
    .NUM_CHAN   (NUM_CHAN),
    .PERIOD_FS  (PERIOD_FS),
    .LEGACY_CAP (LEGACY_CAP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (busWrData),
    .chanHit    (chanHit),
    .rdData     (busRdData),
    .countValue (countValue),
    .runOut     (counterRun),
    .legacyOut  (legacyRouteEn)
  );

endmodule

// File: tb/test_evt_main_counter.sv
module test_evt_main_counter;

  localparam int          AW  = 8;
  localparam int          NC  = 3;
  localparam logic [31:0] PER = 32'd69_841_279;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrEn = 1'b0, busRdEn = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic [NC-1:0] chanHit = '0;
  logic [31:0]   busRdData;
  logic [63:0]   countValue;
  logic          counterRun, legacyRouteEn;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit checkEn = 1'b0;

  always #2.5 clk = ~clk;

  evt_main_counter #(.ADDR_W(AW), .NUM_CHAN(NC), .PERIOD_FS(PER), .LEGACY_CAP(1'b1))
  i_evt_main_counter (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .chanHit(chanHit),
    .countValue(countValue), .counterRun(counterRun), .legacyRouteEn(legacyRouteEn)
  );

  // behavioural reference
  longint unsigned mCount;
  logic [31:0]     mHi, mRd;
  bit              mRun, mLeg;
  logic [NC-1:0]   mStat;
  string           mRdTag = "R9";

  always @(posedge clk) begin
    if (!rstN) begin
      mCount <= 0; mHi <= 0; mRd <= 0; mRun <= 0; mLeg <= 0; mStat <= 0; mRdTag <= "R1";
    end else begin
      mRd <= 0; mRdTag <= "R9";
      if (busRdEn) begin
        case (busAddr)
          8'h00: begin mRd <= 32'(NC - 1) | 32'h100; mRdTag <= "R5"; end
          8'h04: begin mRd <= PER; mRdTag <= "R6"; end
          8'h10: begin mRd <= {30'd0, mLeg, mRun}; mRdTag <= "R7"; end
          8'h20: begin mRd <= 32'(mStat); mRdTag <= "R8"; end
          8'h30: begin mRd <= mCount[31:0]; mHi <= mCount[63:32]; mRdTag <= "R4"; end
          8'h34: begin mRd <= mHi; mRdTag <= "R4"; end
          default: ;
        endcase
      end
      if (mRun) mCount <= mCount + 1;
      else if (busWrEn && busAddr == 8'h30) mCount <= {mCount[63:32], busWrData};
      else if (busWrEn && busAddr == 8'h34) mCount <= {busWrData, mCount[31:0]};
      if (busWrEn && busAddr == 8'h10) begin mRun <= busWrData[0]; mLeg <= busWrData[1]; end
      mStat <= (mStat & ~((busWrEn && busAddr == 8'h20) ? busWrData[NC-1:0] : '0)) | chanHit;
    end
  end

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (checkEn) begin
      check64("R2 R3 count", countValue, mCount);
      check64("R2 run", 64'(counterRun), 64'(mRun));
      check64("R7 legacy", 64'(legacyRouteEn), 64'(mLeg));
      check64({mRdTag, " read"}, 64'(busRdData), 64'(mRd));
    end
    if (cycles > 100000) begin
      misses++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic op(input bit we, input bit re, input logic [7:0] a,
                    input logic [31:0] d, input logic [NC-1:0] h);
    @(negedge clk);
    busWrEn = we; busRdEn = re; busAddr = a; busWrData = d; chanHit = h;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d); op(1, 0, a, d, '0); endtask
  task automatic rd(input logic [7:0] a); op(0, 1, a, 0, '0); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check64("R1 count", countValue, 64'd0);
    check64("R1 run", 64'(counterRun), 64'd0);
    check64("R1 legacy", 64'(legacyRouteEn), 64'd0);
    rstN = 1'b1;
    checkEn = 1'b1;
    rd(8'h00); rd(8'h04); rd(8'h10); rd(8'h20); rd(8'h30); rd(8'h34);
    rd(8'h3C); rd(8'h31);                       // R9 unmapped
    wr(8'h30, 32'hFFFF_FFF0); wr(8'h34, 32'h1); // R3 halted load
    rd(8'h30); rd(8'h34);
    wr(8'h10, 32'h1);                           // R2 run
    idle(14);
    rd(8'h30); idle(1); rd(8'h34);              // R4 around the carry
    wr(8'h30, 32'h1234); wr(8'h34, 32'h5);      // R3 ignored while running
    idle(2);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10);        // R7
    wr(8'h10, 32'h2); idle(3);                  // R2 freeze
    wr(8'h30, 32'h0); wr(8'h34, 32'h0); rd(8'h30); rd(8'h34);
    op(0, 0, 0, 0, 3'b101); rd(8'h20);          // R8 set
    wr(8'h20, 32'h1); rd(8'h20);                // R8 clear
    wr(8'h20, 32'h0); rd(8'h20);
    op(1, 0, 8'h20, 32'h4, 3'b100); rd(8'h20);  // R8 collision: set wins
    op(1, 0, 8'h20, 32'h4, 3'b010); rd(8'h20);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20);
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h12, 32'h1); rd(8'h10); // R9 unmapped writes
    for (int i = 0; i < 400; i++) begin
      logic [2:0] pick = 3'($urandom_range(0, 7));
      logic [7:0] a;
      case (pick)
        3'd0: a = 8'h10; 3'd1: a = 8'h20; 3'd2: a = 8'h30; 3'd3: a = 8'h34;
        3'd4: a = 8'h00; 3'd5: a = 8'h04; default: a = 8'h30;
      endcase
      op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
         (a == 8'h10) ? 32'($urandom_range(0, 3)) : $urandom, NC'($urandom_range(0, 7)));
    end
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule